// File: doc/BRIEF.md
# Microcoded Memory Cycle Sequencer

This block runs memory cycles from a small microcode store. A caller gives a 5-bit cycle type and a 4-bit entry offset and raises `start`. The sequencer then fetches 16-bit control words from the 16-word page that belongs to that cycle type. Each word sets the levels of the five memory strobes for as long as it is current. It also tells a downstream address multiplexer and a downstream data multiplexer what to place on their buses, and it can flag that read data must be captured. The next word always comes from the same page, at the offset named in the current word. A word with its final flag set ends the cycle.

A cycle type can have up to four short variants. Variant *v* is a pair of words at page offsets 2v and 2v+1, and these pairs usually lead into a common tail of words higher up in the page. So the caller chooses a variant by giving an even entry offset. Any word can be held for one extra clock, which gives the slack that asynchronous memory timing needs. After the final word the block gives a one-clock done pulse and rests in a quiet idle state until the next start.

Top module: `ucode_cycle_seq`

## Requirements
- R1: While reset is low, and after it until the first start, `busy` and `done` are 0, `ras_n`, `cas_n`, `we_n` and `trg_n` are 1, `dsf` is 0, `addr_sel` and `data_sel` are 00 and `capture` is 0.
- R2: A start seen at a clock edge while `busy` is 0 is accepted. From the next cycle `busy` is 1 and the outputs show the word at page address {cycle_type, start_ofs}.
- R3: A word's bits are, from bit 15 down: 15 RAS level, 14 CAS level, 13 DSF level, 12 WE level, 11 TRG level, 10 stretch, 9:8 address command, 7:6 data command, 5 capture, 4 final, 3:0 next offset. While the word is current, the strobe outputs carry the stored levels.
- R4: `addr_sel` carries the address command (00 bus released, 01 column, 10 row, 11 block address). `data_sel` carries the data command (00 bus released, 01 write mask, 10 column mask, 11 pixel data).
- R5: `capture` is 1 exactly in the cycles whose current word has its capture bit set.
- R6: A word with the stretch bit set stays current for two clocks. Any other word stays current for one.
- R7: When a non-final word ends, the next word comes from {same cycle type, next offset}. The next offset can point anywhere in the page, including odd entry points.
- R8: When a final word ends, the next cycle has `done` = 1 for one clock and `busy` = 0, with the outputs in the R1 idle state.
- R9: A start raised while `busy` is 1 has no effect on the running cycle. A start still held when `busy` drops (including the done cycle) is accepted then.
- R10: Type 2 is a write cycle with four variants at offsets 0/1, 2/3, 4/5 and 6/7. The first word of each variant drives RAS low with a row address and data command 00, 01, 10 and 01 for variants 0 to 3. The second word adds WE low with a column address and pixel data, and has DSF high only for variant 3. Both variants jump to offset 8, where a stretched word drives CAS and WE low. Offset 9 is a final word with all strobes high.
- R11: Type 1 is a read cycle. Offset 0 is a row address with strobes high. Offset 1 is RAS low with a row address, stretched. Offset 2 is RAS, CAS and TRG low with a column address and capture. Offset 3 is a final word with the strobes high.
- R12: Every page address not filled by R10 or R11 holds a final word with the idle levels, so such a cycle is busy for one clock and then gives done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a cycle |
| cycle_type | input | 5 | Cycle type, selects the 16-word page |
| start_ofs | input | 4 | Entry offset inside the page |
| busy | output | 1 | A cycle word is current |
| done | output | 1 | One-clock pulse after the final word |
| ras_n | output | 1 | RAS level |
| cas_n | output | 1 | CAS level |
| dsf | output | 1 | DSF level |
| we_n | output | 1 | WE level |
| trg_n | output | 1 | TRG / output-enable level |
| addr_sel | output | 2 | Address multiplexer command |
| data_sel | output | 2 | Data multiplexer command |
| capture | output | 1 | Capture read data this cycle |

## Verification
An accepted start shows its first word one clock after the edge that samples it. Each later word follows one clock after the previous one, or two clocks after it if the previous word is stretched. The done pulse comes one clock after the final word. The bench keeps a queue of the expected per-clock output vectors. When a start is accepted, it fills the queue by walking the programs given in R10 to R11, with every stretched word entered twice and one done entry appended. On every falling edge the bench pops one entry, or expects idle when the queue is empty, and compares it with all outputs, so a word that lasts a clock too long or too short is caught in the first cycle it goes wrong.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

    localparam int TYPE_W  = 5;
    localparam int OFS_W   = 4;
    localparam int UADDR_W = TYPE_W + OFS_W;

    // address multiplexer commands
    localparam logic [1:0] ACMD_OFF = 2'b00;
    localparam logic [1:0] ACMD_COL = 2'b01;
    localparam logic [1:0] ACMD_ROW = 2'b10;
    localparam logic [1:0] ACMD_BLK = 2'b11;

    // data multiplexer commands
    localparam logic [1:0] DCMD_OFF = 2'b00;
    localparam logic [1:0] DCMD_WMK = 2'b01;
    localparam logic [1:0] DCMD_CMK = 2'b10;
    localparam logic [1:0] DCMD_PIX = 2'b11;

    typedef struct packed {
        logic             ras;
        logic             cas;
        logic             dsf;
        logic             we;
        logic             trg;
        logic             stretch;
        logic [1:0]       acmd;
        logic [1:0]       dcmd;
        logic             cap;
        logic             last;
        logic [OFS_W-1:0] jmp;
    } uword_t;

    localparam uword_t IDLE_WORD = '{ras: 1'b1, cas: 1'b1, dsf: 1'b0, we: 1'b1,
                                     trg: 1'b1, stretch: 1'b0, acmd: ACMD_OFF,
                                     dcmd: DCMD_OFF, cap: 1'b0, last: 1'b1,
                                     jmp: '0};

endpackage

// File: rtl/ucs_rom.sv
module ucs_rom
    import ucs_pkg::*;
#(
    parameter int TW = TYPE_W,
    parameter int OW = OFS_W
) (
    input  logic [TW+OW-1:0] addr,
    output uword_t           word
);

    localparam int PAGE_TAIL = 8;

    function automatic uword_t mk(logic r, logic c, logic d, logic w, logic t,
                                  logic s, logic [1:0] a, logic [1:0] dc,
                                  logic cp, logic l, logic [OW-1:0] j);
        uword_t u;
        u.ras = r; u.cas = c; u.dsf = d; u.we = w; u.trg = t;
        u.stretch = s; u.acmd = a; u.dcmd = dc; u.cap = cp; u.last = l;
        u.jmp = j;
        return u;
    endfunction

    function automatic logic [1:0] variant_lead_dcmd(logic [1:0] v);
        case (v)
            2'd0:    return DCMD_OFF;
            2'd1:    return DCMD_WMK;
            2'd2:    return DCMD_CMK;
            default: return DCMD_WMK;
        endcase
    endfunction

    function automatic uword_t read_page(logic [OW-1:0] o);
        case (o)
            OW'(0):  return mk(1, 1, 0, 1, 1, 0, ACMD_ROW, DCMD_OFF, 0, 0, OW'(1));
            OW'(1):  return mk(0, 1, 0, 1, 1, 1, ACMD_ROW, DCMD_OFF, 0, 0, OW'(2));
            OW'(2):  return mk(0, 0, 0, 1, 0, 0, ACMD_COL, DCMD_OFF, 1, 0, OW'(3));
            OW'(3):  return mk(1, 1, 0, 1, 1, 0, ACMD_OFF, DCMD_OFF, 0, 1, OW'(0));
            default: return IDLE_WORD;
        endcase
    endfunction

    function automatic uword_t write_page(logic [OW-1:0] o);
        logic [1:0] v;
        v = o[2:1];
        if (o < OW'(PAGE_TAIL)) begin
            if (!o[0])
                return mk(0, 1, 0, 1, 1, 0, ACMD_ROW, variant_lead_dcmd(v), 0, 0,
                          {o[OW-1:1], 1'b1});
            else
                return mk(0, 1, (v == 2'd3), 0, 1, 0, ACMD_COL, DCMD_PIX, 0, 0,
                          OW'(PAGE_TAIL));
        end
        else if (o == OW'(PAGE_TAIL))
            return mk(0, 0, 0, 0, 1, 1, ACMD_COL, DCMD_PIX, 0, 0, OW'(PAGE_TAIL + 1));
        else if (o == OW'(PAGE_TAIL + 1))
            return mk(1, 1, 0, 1, 1, 0, ACMD_OFF, DCMD_OFF, 0, 1, OW'(0));
        else
            return IDLE_WORD;
    endfunction

    logic [TW-1:0] page;
    logic [OW-1:0] ofs;

    assign page = addr[TW+OW-1:OW];
    assign ofs  = addr[OW-1:0];

    always_comb begin
        case (page)
            TW'(1):  word = read_page(ofs);
            TW'(2):  word = write_page(ofs);
            default: word = IDLE_WORD;
        endcase
    end

endmodule

// File: rtl/ucs_seq.sv
module ucs_seq
    import ucs_pkg::*;
#(
    parameter int TW = TYPE_W,
    parameter int OW = OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TW-1:0]    ctype_i,
    input  logic [OW-1:0]    ofs_i,
    input  uword_t           rom_word,
    output logic [TW+OW-1:0] rom_addr,
    output uword_t           word_q,
    output logic             active_q,
    output logic             done_q
);

    typedef struct packed {
        logic          active;
        logic          hold;
        logic          done;
        logic [TW-1:0] ctype;
        uword_t        word;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       launch;

    assign launch = start && !s_q.active;

    always_comb begin
        if (launch) rom_addr = {ctype_i, ofs_i};
        else        rom_addr = {s_q.ctype, s_q.word.jmp};
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.hold   = 1'b0;
                s_d.ctype  = ctype_i;
                s_d.word   = rom_word;
            end
        end
        else if (s_q.word.stretch && !s_q.hold) begin
            s_d.hold = 1'b1;
        end
        else begin
            s_d.hold = 1'b0;
            if (s_q.word.last) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
                s_d.word   = IDLE_WORD;
            end
            else begin
                s_d.word = rom_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.active <= 1'b0;
            s_q.hold   <= 1'b0;
            s_q.done   <= 1'b0;
            s_q.ctype  <= '0;
            s_q.word   <= IDLE_WORD;
        end
        else begin
            s_q <= s_d;
        end
    end

    assign word_q   = s_q.word;
    assign active_q = s_q.active;
    assign done_q   = s_q.done;

endmodule

// File: rtl/ucs_decode.sv
module ucs_decode (
    input  logic       active,
    input  logic       ras_f,
    input  logic       cas_f,
    input  logic       dsf_f,
    input  logic       we_f,
    input  logic       trg_f,
    input  logic [1:0] acmd_f,
    input  logic [1:0] dcmd_f,
    input  logic       cap_f,
    output logic       ras_n,
    output logic       cas_n,
    output logic       dsf,
    output logic       we_n,
    output logic       trg_n,
    output logic [1:0] addr_sel,
    output logic [1:0] data_sel,
    output logic       capture
);

    always_comb begin
        if (active) begin
            ras_n    = ras_f;
            cas_n    = cas_f;
            dsf      = dsf_f;
            we_n     = we_f;
            trg_n    = trg_f;
            addr_sel = acmd_f;
            data_sel = dcmd_f;
            capture  = cap_f;
        end
        else begin
            ras_n    = 1'b1;
            cas_n    = 1'b1;
            dsf      = 1'b0;
            we_n     = 1'b1;
            trg_n    = 1'b1;
            addr_sel = 2'b00;
            data_sel = 2'b00;
            capture  = 1'b0;
        end
    end

endmodule

// File: rtl/ucode_cycle_seq.sv
module ucode_cycle_seq
    import ucs_pkg::*;
#(
    parameter int TW = TYPE_W,
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] cycle_type,
    input  logic [OW-1:0] start_ofs,
    output logic          busy,
    output logic          done,
    output logic          ras_n,
    output logic          cas_n,
    output logic          dsf,
    output logic          we_n,
    output logic          trg_n,
    output logic [1:0]    addr_sel,
    output logic [1:0]    data_sel,
    output logic          capture
);

    localparam int AW = TW + OW;

    logic [AW-1:0] rom_addr;
    uword_t        rom_word;
    uword_t        cur_word;
    logic          active;

    ucs_rom #(.TW(TW), .OW(OW)) u_rom (
        .addr (rom_addr),
        .word (rom_word)
    );

    ucs_seq #(.TW(TW), .OW(OW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ctype_i  (cycle_type),
        .ofs_i    (start_ofs),
        .rom_word (rom_word),
        .rom_addr (rom_addr),
        .word_q   (cur_word),
        .active_q (active),
        .done_q   (done)
    );

    ucs_decode u_dec (
        .active   (active),
        .ras_f    (cur_word.ras),
        .cas_f    (cur_word.cas),
        .dsf_f    (cur_word.dsf),
        .we_f     (cur_word.we),
        .trg_f    (cur_word.trg),
        .acmd_f   (cur_word.acmd),
        .dcmd_f   (cur_word.dcmd),
        .cap_f    (cur_word.cap),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .dsf      (dsf),
        .we_n     (we_n),
        .trg_n    (trg_n),
        .addr_sel (addr_sel),
        .data_sel (data_sel),
        .capture  (capture)
    );

    assign busy = active;

endmodule

// File: rtl/ucs_checker.sv
module ucs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       ras_n,
    input logic       cas_n,
    input logic       dsf,
    input logic       we_n,
    input logic       trg_n,
    input logic [1:0] addr_sel,
    input logic [1:0] data_sel,
    input logic       capture
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ras_n && cas_n && we_n && trg_n && !dsf &&
                   addr_sel == 2'b00 && data_sel == 2'b00 && !capture));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5
    capture_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (busy && !cas_n));

endmodule

bind ucode_cycle_seq ucs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .dsf      (dsf),
    .we_n     (we_n),
    .trg_n    (trg_n),
    .addr_sel (addr_sel),
    .data_sel (data_sel),
    .capture  (capture)
);

// File: tb/ucode_cycle_seq_bench.sv
module ucode_cycle_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [4:0] cycle_type;
    logic [3:0] start_ofs;
    logic       busy, done, ras_n, cas_n, dsf, we_n, trg_n, capture;
    logic [1:0] addr_sel, data_sel;

    always #2 clk = ~clk;

    ucode_cycle_seq u_ucode_cycle_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cycle_type(cycle_type),
        .start_ofs(start_ofs), .busy(busy), .done(done), .ras_n(ras_n),
        .cas_n(cas_n), .dsf(dsf), .we_n(we_n), .trg_n(trg_n),
        .addr_sel(addr_sel), .data_sel(data_sel), .capture(capture)
    );

    int checks = 0;
    int fails  = 0;
    string tag = "R1";
    logic [11:0] expq[$];

    localparam logic [11:0] IDLE_VEC = 12'b11011_00_00_0_0_0;
    localparam logic [11:0] DONE_VEC = 12'b11011_00_00_0_0_1;

    // word per R3: {ras,cas,dsf,we,trg,stretch,acmd[2],dcmd[2],cap,final,next[4]}
    function automatic logic [15:0] w(bit r, bit c, bit d, bit we, bit t, bit s,
                                      bit [1:0] a, bit [1:0] dc, bit cp, bit l,
                                      bit [3:0] j);
        return {r, c, d, we, t, s, a, dc, cp, l, j};
    endfunction

    // programs of R10, R11, R12
    function automatic logic [15:0] spec_word(int t, int o);
        bit [1:0] lead [4] = '{2'b00, 2'b01, 2'b10, 2'b01};
        if (t == 1) begin
            if (o == 0) return w(1,1,0,1,1,0,2'b10,2'b00,0,0,4'd1);
            if (o == 1) return w(0,1,0,1,1,1,2'b10,2'b00,0,0,4'd2);
            if (o == 2) return w(0,0,0,1,0,0,2'b01,2'b00,1,0,4'd3);
            if (o == 3) return w(1,1,0,1,1,0,2'b00,2'b00,0,1,4'd0);
        end
        if (t == 2) begin
            if (o < 8 && o % 2 == 0) return w(0,1,0,1,1,0,2'b10,lead[o/2],0,0,4'(o+1));
            if (o < 8)               return w(0,1,(o/2 == 3),0,1,0,2'b01,2'b11,0,0,4'd8);
            if (o == 8)              return w(0,0,0,0,1,1,2'b01,2'b11,0,0,4'd9);
            if (o == 9)              return w(1,1,0,1,1,0,2'b00,2'b00,0,1,4'd0);
        end
        return w(1,1,0,1,1,0,2'b00,2'b00,0,1,4'd0);
    endfunction

    task automatic push_program(int t, int o);
        int ofs = o;
        for (int n = 0; n < 40; n++) begin
            logic [15:0] wd = spec_word(t, ofs);
            logic [11:0] v = {wd[15:11], wd[9:8], wd[7:6], wd[5], 1'b1, 1'b0};
            expq.push_back(v);
            if (wd[10]) expq.push_back(v);
            if (wd[4]) break;
            ofs = int'(wd[3:0]);
        end
        expq.push_back(DONE_VEC);
    endtask

    task automatic compare();
        logic [11:0] exp_v, act_v;
        exp_v = (expq.size() > 0) ? expq.pop_front() : IDLE_VEC;
        act_v = {ras_n, cas_n, dsf, we_n, trg_n, addr_sel, data_sel, capture, busy, done};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic step(bit s, int t, int o);
        @(negedge clk);
        compare();
        start      = s;
        cycle_type = 5'(t);
        start_ofs  = 4'(o);
        if (s && expq.size() == 0) push_program(t, o);
    endtask

    task automatic run(int t, int o);
        step(1, t, o);
        repeat (12) step(0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; cycle_type = '0; start_ofs = '0;
        tag = "R1 reset idle";
        repeat (3) step(0, 0, 0);
        rst_n = 1'b1;
        repeat (2) step(0, 0, 0);

        tag = "R11 R2 R3 R5 R6 R8 read";
        run(1, 0);
        tag = "R10 R4 R7 write v0";
        run(2, 0);
        tag = "R10 R4 write v1";
        run(2, 2);
        tag = "R10 R4 write v2";
        run(2, 4);
        tag = "R10 R3 write v3 dsf";
        run(2, 6);
        tag = "R7 odd entry";
        run(2, 3);
        tag = "R12 empty page";
        run(9, 0);
        tag = "R12 empty offset";
        run(1, 7);
        tag = "R12 last page";
        run(31, 15);

        tag = "R9 start while busy";
        step(1, 1, 0);
        repeat (3) step(1, 2, 4);
        step(0, 2, 4);
        repeat (14) step(0, 0, 0);

        tag = "R9 R2 start held into done";
        step(1, 2, 6);
        repeat (9) step(1, 1, 0);
        repeat (16) step(0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule